// File: doc/BRIEF.md
# Programmable Raster Sync and Data-Enable Generator

This block produces the line sync, frame sync, data-enable and pixel-request strobes for a parallel RGB panel clocked by a dot clock. The line is described by its total length in dot clocks, its sync pulse width, the wait from sync start to the first active pixel, and the number of active pixels. The frame is described the same way, counted in lines. Each strobe has its own selectable active level. A dot-clock edge select is passed through to the pixel data path. A frame base address is double-buffered: software writes the next address at any time, and it becomes the current address only on the frame boundary.

All timing and polarity settings are held in shadow registers. These track the inputs while the syncs are off and reload only at the frame boundary once the syncs run, so a change made mid-frame never bends the frame in progress. A small state machine orders start and stop. The syncs must be running before pixel transfers can begin, and pixel transfers begin only at a frame boundary. A stop request lets the current frame finish. The syncs can be switched off only after the run status has cleared.

States and transitions: `ST_OFF` (counters held at zero, outputs at inactive level) goes to `ST_BLANK` when `sync_en` is high. `ST_BLANK` (syncs running, no pixels) goes back to `ST_OFF` when `sync_en` is low, and goes to `ST_ACTIVE` at a frame boundary when `run_req` is high. `ST_ACTIVE` (pixels flowing) goes to `ST_DRAIN` when `run_req` drops. `ST_DRAIN` (stop pending, pixels still flowing) goes, at the frame boundary, to `ST_ACTIVE` if `run_req` and `sync_en` are both high again, and otherwise to `ST_BLANK`.

Top module: `panel_timing_gen`

## Requirements
- R1: While the syncs are disabled (`sync_en` low), `hsync_o`, `vsync_o` and `de_o` sit at their inactive level, and `pix_req_o` and `running_o` are 0. A polarity bit of 1 means active high, and the inactive level is then 0; a polarity bit of 0 means active low.
- R2: The line sync repeats every `cfg_line_total` dot clocks and is active for `cfg_hs_width` dot clocks, starting at dot clock 0 of each line.
- R3: On an active line, data-enable rises `cfg_h_wait` dot clocks after the line sync start and stays active for exactly `cfg_h_active` dot clocks.
- R4: The frame sync repeats every `cfg_frame_total` lines and is active for `cfg_vs_width` whole lines, starting together with a line sync.
- R5: The first active line is `cfg_v_wait` lines after the frame sync start, and exactly `cfg_v_active` consecutive lines carry data-enable.
- R6: Each of the three strobes follows its own polarity bit (`cfg_hs_high`, `cfg_vs_high`, `cfg_de_high`), and `pix_edge_fall_o` follows `cfg_edge_fall`.
- R7: `cur_base` takes the value of `next_base` only at the frame boundary. `frame_done_o` is a one-cycle pulse in the first cycle after the boundary, and `cur_base` already holds the new address in that cycle.
- R8: A timing setting changed mid-frame leaves the rest of that frame unchanged and takes effect from the next frame.
- R9: Pixel transfer (`running_o` high, data-enable active) starts only at a frame boundary while the syncs run. A run request with the syncs disabled produces no data-enable.
- R10: Dropping `run_req` mid-frame lets the frame finish with all its active pixels. `running_o` clears at the boundary. The syncs keep running afterwards.
- R11: `pix_req_o` is high exactly one dot clock before each cycle in which `de_o` is active.
- R12: Dropping `sync_en` while pixels are flowing has no effect until `running_o` has cleared. The syncs stop after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | Enable for the sync outputs |
| run_req | input | 1 | Request for pixel transfers |
| cfg_line_total | input | HW | Dot clocks per line |
| cfg_hs_width | input | HW | Line sync width in dot clocks |
| cfg_h_wait | input | HW | Dot clocks from line sync start to first pixel |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_frame_total | input | VW | Lines per frame |
| cfg_vs_width | input | VW | Frame sync width in lines |
| cfg_v_wait | input | VW | Lines from frame sync start to first active line |
| cfg_v_active | input | VW | Active lines per frame |
| cfg_hs_high | input | 1 | Line sync active high when 1 |
| cfg_vs_high | input | 1 | Frame sync active high when 1 |
| cfg_de_high | input | 1 | Data-enable active high when 1 |
| cfg_edge_fall | input | 1 | Sample pixel data on the falling dot-clock edge when 1 |
| next_base | input | AW | Frame base address for the next frame |
| cur_base | output | AW | Frame base address in use |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data-enable |
| pix_req_o | output | 1 | Pixel request, one cycle ahead of data-enable |
| pix_edge_fall_o | output | 1 | Dot-clock edge select in use |
| running_o | output | 1 | Pixel transfer in progress |
| frame_done_o | output | 1 | One-cycle pulse after each frame boundary |

## Verification
The assertions assume legal settings. Each total is at least 2. Each sync width is at least 1 and below its total. Wait plus active span fits within the total. Under these settings the counters stay below their totals and a frame lasts more than one cycle. The bench draws every random configuration inside those bounds: it picks the sync width first, then the wait at or above it, then the active span, and then a total that covers all three. All settings are written while the syncs are off, except in the one directed mid-frame change, which stays within bounds.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_BLANK  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DRAIN  = 2'd3
    } ptg_state_e;

    // Map a logical "asserted" flag to a pin level under a polarity bit.
    function automatic logic pin_level(input logic asserted, input logic active_high);
        return active_high ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/ptg_axis_cnt.sv
module ptg_axis_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] total,
    input  logic [W-1:0] pulse_w,
    input  logic [W-1:0] wait_c,
    input  logic [W-1:0] span,
    output logic         at_last,
    output logic         in_pulse,
    output logic         in_span
);
    localparam int EW = W + 1;

    logic [W-1:0]  cnt;
    logic [EW-1:0] span_end;

    assign span_end = {1'b0, wait_c} + {1'b0, span};
    assign at_last  = (cnt == total - W'(1));
    assign in_pulse = (cnt < pulse_w);
    assign in_span  = ({1'b0, cnt} >= {1'b0, wait_c}) && ({1'b0, cnt} < span_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_last ? '0 : cnt + W'(1);
        end
    end

    // R2 (line counter) and R4 (frame counter): the position never leaves the period.
    assert_cnt_below_total_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (total > W'(1)) |-> (cnt < total));

endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic run_req,
    input  logic wrap,
    output logic sync_on,
    output logic data_on
);
    import ptg_pkg::*;

    ptg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sync_en) state_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (!sync_en)            state_d = ST_OFF;
                else if (wrap && run_req) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!run_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wrap) state_d = (run_req && sync_en) ? ST_ACTIVE : ST_BLANK;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        sync_on = 1'b0;
        data_on = 1'b0;
        unique case (state_q)
            ST_OFF:    begin sync_on = 1'b0; data_on = 1'b0; end
            ST_BLANK:  begin sync_on = 1'b1; data_on = 1'b0; end
            ST_ACTIVE: begin sync_on = 1'b1; data_on = 1'b1; end
            ST_DRAIN:  begin sync_on = 1'b1; data_on = 1'b1; end
            default:   begin sync_on = 1'b0; data_on = 1'b0; end
        endcase
    end

    // R12: the syncs are only ever shut off from the idle-sync state.
    assert_stop_after_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_OFF) && ($past(state_q) != ST_OFF)) |-> ($past(state_q) == ST_BLANK));

    // R10: a drain always completes at a frame boundary.
    assert_drain_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && !wrap) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en,
    input  logic          run_req,
    input  logic [HW-1:0] cfg_line_total,
    input  logic [HW-1:0] cfg_hs_width,
    input  logic [HW-1:0] cfg_h_wait,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [VW-1:0] cfg_frame_total,
    input  logic [VW-1:0] cfg_vs_width,
    input  logic [VW-1:0] cfg_v_wait,
    input  logic [VW-1:0] cfg_v_active,
    input  logic          cfg_hs_high,
    input  logic          cfg_vs_high,
    input  logic          cfg_de_high,
    input  logic          cfg_edge_fall,
    input  logic [AW-1:0] next_base,
    output logic [AW-1:0] cur_base,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pix_req_o,
    output logic          pix_edge_fall_o,
    output logic          running_o,
    output logic          frame_done_o
);
    import ptg_pkg::*;

    logic sync_on, data_on, wrap, load;
    logic h_last, h_pulse, h_span;
    logic v_last, v_pulse, v_span;

    // Shadowed timing, reloaded only while off or at the frame boundary.
    logic [HW-1:0] sh_line_total, sh_hs_width, sh_h_wait, sh_h_active;
    logic [VW-1:0] sh_frame_total, sh_vs_width, sh_v_wait, sh_v_active;
    logic          sh_hs_high, sh_vs_high, sh_de_high, sh_edge_fall;

    assign wrap = sync_on && h_last && v_last;
    assign load = !sync_on || wrap;

    ptg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (sync_en),
        .run_req (run_req),
        .wrap    (wrap),
        .sync_on (sync_on),
        .data_on (data_on)
    );

    ptg_axis_cnt #(.W(HW)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!sync_on),
        .step     (sync_on),
        .total    (sh_line_total),
        .pulse_w  (sh_hs_width),
        .wait_c   (sh_h_wait),
        .span     (sh_h_active),
        .at_last  (h_last),
        .in_pulse (h_pulse),
        .in_span  (h_span)
    );

    ptg_axis_cnt #(.W(VW)) u_vcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!sync_on),
        .step     (sync_on && h_last),
        .total    (sh_frame_total),
        .pulse_w  (sh_vs_width),
        .wait_c   (sh_v_wait),
        .span     (sh_v_active),
        .at_last  (v_last),
        .in_pulse (v_pulse),
        .in_span  (v_span)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_line_total  <= '0;
            sh_hs_width    <= '0;
            sh_h_wait      <= '0;
            sh_h_active    <= '0;
            sh_frame_total <= '0;
            sh_vs_width    <= '0;
            sh_v_wait      <= '0;
            sh_v_active    <= '0;
            sh_hs_high     <= 1'b0;
            sh_vs_high     <= 1'b0;
            sh_de_high     <= 1'b0;
            sh_edge_fall   <= 1'b0;
            cur_base       <= '0;
        end else if (load) begin
            sh_line_total  <= cfg_line_total;
            sh_hs_width    <= cfg_hs_width;
            sh_h_wait      <= cfg_h_wait;
            sh_h_active    <= cfg_h_active;
            sh_frame_total <= cfg_frame_total;
            sh_vs_width    <= cfg_vs_width;
            sh_v_wait      <= cfg_v_wait;
            sh_v_active    <= cfg_v_active;
            sh_hs_high     <= cfg_hs_high;
            sh_vs_high     <= cfg_vs_high;
            sh_de_high     <= cfg_de_high;
            sh_edge_fall   <= cfg_edge_fall;
            cur_base       <= next_base;
        end
    end

    assign pix_req_o       = data_on && h_span && v_span;
    assign running_o       = data_on;
    assign pix_edge_fall_o = sh_edge_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_o      <= 1'b1;
            vsync_o      <= 1'b1;
            de_o         <= 1'b1;
            frame_done_o <= 1'b0;
        end else begin
            hsync_o      <= pin_level(sync_on && h_pulse, sh_hs_high);
            vsync_o      <= pin_level(sync_on && v_pulse, sh_vs_high);
            de_o         <= pin_level(pix_req_o, sh_de_high);
            frame_done_o <= wrap;
        end
    end

    // R7: the base address holds steady between frame boundaries.
    assert_base_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on && !wrap) |=> $stable(cur_base));

    // R7: the frame marker lasts a single cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R9: pixel transfer starts together with a frame marker.
    assert_run_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> frame_done_o);

    // R10: pixel transfer stops together with a frame marker.
    assert_stop_on_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> frame_done_o);

endmodule

// File: tb/test_panel_timing_gen.sv
`timescale 1ns/1ps
module test_panel_timing_gen;
    localparam int HW = 12;
    localparam int VW = 12;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_en = 1'b0, run_req = 1'b0;
    logic [HW-1:0] cfg_line_total = '0, cfg_hs_width = '0, cfg_h_wait = '0, cfg_h_active = '0;
    logic [VW-1:0] cfg_frame_total = '0, cfg_vs_width = '0, cfg_v_wait = '0, cfg_v_active = '0;
    logic cfg_hs_high = 1'b0, cfg_vs_high = 1'b0, cfg_de_high = 1'b0, cfg_edge_fall = 1'b0;
    logic [AW-1:0] next_base = '0;
    logic [AW-1:0] cur_base;
    logic hsync_o, vsync_o, de_o, pix_req_o, pix_edge_fall_o, running_o, frame_done_o;

    int n_total = 0, n_bad = 0;
    bit finished = 0;
    int lt, hs, hw, ha, ft, vs, vw, va;

    always #4 clk = ~clk;

    panel_timing_gen #(.HW(HW), .VW(VW), .AW(AW)) i_panel_timing_gen (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .run_req(run_req),
        .cfg_line_total(cfg_line_total), .cfg_hs_width(cfg_hs_width),
        .cfg_h_wait(cfg_h_wait), .cfg_h_active(cfg_h_active),
        .cfg_frame_total(cfg_frame_total), .cfg_vs_width(cfg_vs_width),
        .cfg_v_wait(cfg_v_wait), .cfg_v_active(cfg_v_active),
        .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
        .cfg_de_high(cfg_de_high), .cfg_edge_fall(cfg_edge_fall),
        .next_base(next_base), .cur_base(cur_base),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req_o(pix_req_o),
        .pix_edge_fall_o(pix_edge_fall_o), .running_o(running_o), .frame_done_o(frame_done_o)
    );

    // Expected values from the requirements.
    function automatic int exp_first_de(int l_tot, int v_wait, int h_wait);
        return v_wait * l_tot + h_wait;
    endfunction
    function automatic int exp_frame_cycles(int l_tot, int f_tot);
        return l_tot * f_tot;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg();
        cfg_line_total  = HW'(lt); cfg_hs_width = HW'(hs); cfg_h_wait = HW'(hw); cfg_h_active = HW'(ha);
        cfg_frame_total = VW'(ft); cfg_vs_width = VW'(vs); cfg_v_wait = VW'(vw); cfg_v_active = VW'(va);
    endtask

    task automatic wait_running(input bit level);
        for (int g = 0; g < 5000 && running_o != level; g++) @(negedge clk);
    endtask

    task automatic wait_done();
        @(negedge clk);
        for (int g = 0; g < 5000 && !frame_done_o; g++) @(negedge clk);
    endtask

    // Measure one active frame starting at a frame sync start (R2..R5, R11).
    task automatic measure_frame(input string tag);
        bit pv, started, prev_req;
        int n, hs_cnt, vs_cnt, de_cnt, first_de, line_de, line0_de, de_lines, lag_err;
        bit line_had;
        wait_running(1'b1);
        started = 0;
        pv = (vsync_o == cfg_vs_high);
        for (int g = 0; g < 5000 && !started; g++) begin
            @(negedge clk);
            if ((vsync_o == cfg_vs_high) && !pv) started = 1;
            else pv = (vsync_o == cfg_vs_high);
        end
        n = exp_frame_cycles(lt, ft);
        hs_cnt = 0; vs_cnt = 0; de_cnt = 0; first_de = -1; line_de = 0; line0_de = -1;
        de_lines = 0; lag_err = 0; line_had = 0; prev_req = 0;
        for (int idx = 0; idx < n; idx++) begin
            bit hact_s, vact_s, dact_s;
            hact_s = (hsync_o == cfg_hs_high);
            vact_s = (vsync_o == cfg_vs_high);
            dact_s = (de_o == cfg_de_high);
            if (idx > 0 && dact_s != prev_req) lag_err++;
            prev_req = pix_req_o;
            if (idx == lt - 1) chk("R2", {tag, " hsync off before next line"}, hact_s, 0);
            if (idx == lt)     chk("R2", {tag, " hsync at next line start"}, hact_s, 1);
            hs_cnt += hact_s;
            vs_cnt += vact_s;
            if (dact_s) begin
                de_cnt++; line_de++; line_had = 1;
                if (first_de < 0) first_de = idx;
            end
            if ((idx % lt) == lt - 1) begin
                if (line_had) begin
                    if (line0_de < 0) line0_de = line_de;
                    de_lines++;
                end
                line_had = 0; line_de = 0;
            end
            @(negedge clk);
        end
        chk("R4", {tag, " vsync at next frame start"}, (vsync_o == cfg_vs_high), 1);
        chk("R2", {tag, " hsync cycles per frame"}, hs_cnt, hs * ft);
        chk("R4", {tag, " vsync cycles"}, vs_cnt, vs * lt);
        chk("R3", {tag, " pixels on first active line"}, line0_de, ha);
        chk("R3", {tag, " pixel column"}, first_de % lt, hw);
        chk("R5", {tag, " first active pixel offset"}, first_de, exp_first_de(lt, vw, hw));
        chk("R5", {tag, " active lines"}, de_lines, va);
        chk("R11", {tag, " pix_req lead mismatches"}, lag_err, 0);
    endtask

    task automatic stop_all();
        run_req = 1'b0;
        wait_running(1'b0);
        sync_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++; n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin : main
        int c, hcnt, dcnt;
        logic [AW-1:0] old_b;
        void'($urandom(32'd20240611));

        // R1: reset and syncs disabled
        cfg_hs_high = 1'b1; cfg_vs_high = 1'b0; cfg_de_high = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "hsync idle", hsync_o, 0);
        chk("R1", "vsync idle", vsync_o, 1);
        chk("R1", "de idle", de_o, 0);
        chk("R1", "pix_req idle", pix_req_o, 0);
        chk("R1", "running idle", running_o, 0);

        // Directed configuration
        lt = 20; hs = 3; hw = 6; ha = 10; ft = 10; vs = 2; vw = 4; va = 4;
        apply_cfg();
        cfg_edge_fall = 1'b1;
        next_base = 32'h1000_0000;
        run_req = 1'b1; sync_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6", "edge select", pix_edge_fall_o, 1);
        measure_frame("directed");

        // R7: base swap only at the boundary
        wait_done();
        repeat (5) @(negedge clk);
        old_b = cur_base;
        next_base = 32'h2345_6780;
        @(negedge clk);
        chk("R7", "base held mid-frame", cur_base, old_b);
        wait_done();
        chk("R7", "base swapped at boundary", cur_base, 32'h2345_6780);
        @(negedge clk);
        chk("R7", "frame_done one cycle", frame_done_o, 0);

        // R8: mid-frame line length change
        wait_done();
        repeat (3) @(negedge clk);
        cfg_line_total = HW'(lt + 4);
        c = 3;
        for (int g = 0; g < 5000; g++) begin @(negedge clk); c++; if (frame_done_o) break; end
        chk("R8", "frame with old line length", c, exp_frame_cycles(lt, ft));
        lt = lt + 4;
        c = 0;
        for (int g = 0; g < 5000; g++) begin @(negedge clk); c++; if (frame_done_o) break; end
        chk("R8", "frame with new line length", c, exp_frame_cycles(lt, ft));

        // R10: graceful stop
        dcnt = 0;
        for (int k = 1; k < 5000; k++) begin
            @(negedge clk);
            dcnt += (de_o == cfg_de_high);
            if (k == (vw + 1) * lt) begin
                run_req = 1'b0;
                @(negedge clk);
                k++;
                dcnt += (de_o == cfg_de_high);
                chk("R10", "running after stop request", running_o, 1);
            end
            if (frame_done_o) break;
        end
        chk("R10", "pixels of finishing frame", dcnt, ha * va);
        chk("R10", "running cleared at boundary", running_o, 0);
        dcnt = 0; hcnt = 0;
        for (int k = 0; k < exp_frame_cycles(lt, ft); k++) begin
            @(negedge clk);
            dcnt += (de_o == cfg_de_high);
            hcnt += (hsync_o == cfg_hs_high);
        end
        chk("R10", "no pixels after stop", dcnt, 0);
        chk("R10", "syncs still running", hcnt, hs * ft);

        // R12: sync disable deferred while running
        run_req = 1'b1;
        wait_running(1'b1);
        sync_en = 1'b0;
        hcnt = 0;
        for (int k = 0; k < 2 * exp_frame_cycles(lt, ft); k++) begin
            @(negedge clk);
            hcnt += (hsync_o == cfg_hs_high);
        end
        chk("R12", "still running after sync disable", running_o, 1);
        chk("R12", "syncs kept during run", hcnt, 2 * hs * ft);
        run_req = 1'b0;
        wait_running(1'b0);
        repeat (3) @(negedge clk);
        hcnt = 0;
        for (int k = 0; k < 2 * lt; k++) begin
            @(negedge clk);
            hcnt += (hsync_o == cfg_hs_high);
        end
        chk("R12", "syncs off after run cleared", hcnt, 0);

        // R9: run request without syncs
        run_req = 1'b1;
        dcnt = 0; c = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            dcnt += (de_o == cfg_de_high);
            c += running_o + pix_req_o;
        end
        chk("R9", "no pixels without syncs", dcnt, 0);
        chk("R9", "no run without syncs", c, 0);
        run_req = 1'b0;

        // Constrained random configurations
        for (int it = 0; it < 6; it++) begin
            hs = 1 + int'($urandom % 4);  hw = hs + int'($urandom % 5);
            ha = 1 + int'($urandom % 8);  lt = hw + ha + int'($urandom % 6);
            vs = 1 + int'($urandom % 3);  vw = vs + int'($urandom % 3);
            va = 1 + int'($urandom % 4);  ft = vw + va + int'($urandom % 3);
            apply_cfg();
            cfg_hs_high = 1'($urandom); cfg_vs_high = 1'($urandom);
            cfg_de_high = 1'($urandom); cfg_edge_fall = 1'($urandom);
            run_req = 1'b1; sync_en = 1'b1;
            repeat (2) @(negedge clk);
            chk("R6", "edge select random", pix_edge_fall_o, cfg_edge_fall);
            measure_frame("random");
            stop_all();
            chk("R6", "hsync inactive level", hsync_o, !cfg_hs_high);
            chk("R6", "vsync inactive level", vsync_o, !cfg_vs_high);
            chk("R6", "de inactive level", de_o, !cfg_de_high);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule